// File: doc/BRIEF.md
# Multichannel ADC Result and Status Flags

This block holds the conversion results and the status flags of a multichannel successive-approximation converter. A channel sequencer reports each finished conversion with a one-cycle strobe, a channel index and a result word. Register-bus logic reports its own events as strobes: reads of a per-channel data register, reads of the last-converted data register, reads of the status register, and writes that enable or disable channels. From these events the block keeps, for each channel, the stored result, an end-of-conversion flag and an overrun flag. It also keeps a global data-ready flag, a global overrun flag and a last-converted register that records the result and its source channel.

The block is defined by how it resolves events that arrive in the same cycle. A read never clears a flag on a channel other than the one it addresses. A disable never hides an overrun that a completion on another channel raises. A completion for a channel that was disabled in mid-conversion is dropped. A new completion outranks a read that would clear the flag it sets. The block also holds the converter's sleep state. A sleep setting only takes effect when a conversion ends.

Top module: `adcrs_top`

## Requirements
- R1: After reset every flag, every enable bit, every stored result, the last-converted result and channel, and the sleep output are zero.
- R2: On each clock the enable register becomes (chan_en | en_set) & ~en_clr. A bit raised in both masks in one cycle ends up disabled.
- R3: A completion is accepted only if its channel was enabled before the cycle and is not in en_clr that cycle. An accepted completion stores conv_data in that channel's result register and in last_data, stores conv_ch in last_ch, and sets eoc_flags[conv_ch] and drdy on the next clock.
- R4: chan_rdata shows the stored result of channel rd_chan_sel combinationally. A rd_chan strobe clears eoc_flags[rd_chan_sel] only. An accepted completion on the same channel in the same cycle leaves the flag set.
- R5: A rd_last strobe clears drdy and the end-of-conversion flag of the channel held in last_ch before that clock. An accepted completion in the same cycle sets drdy and its own flag anyway.
- R6: An accepted completion on channel c sets ovr_flags[c] when eoc_flags[c] was set and no read cleared it in that same cycle.
- R7: An accepted completion sets govr when drdy was set and no rd_last happened in that cycle. This holds whatever channel produced the unread last-converted data.
- R8: The flag outputs show their values before any clear caused by the read. A rd_status strobe clears every overrun flag and govr, except an overrun that the same cycle's completion raises. A completion on a channel whose end-of-conversion flag is already clear does not keep its overrun flag set.
- R9: Disabling a channel in the same cycle as an accepted completion on a channel x, with drdy and eoc_flags[x] already set, still sets both govr and ovr_flags[x].
- R10: A completion on a channel that is disabled changes no result, no flag and neither last_data nor last_ch. This holds even when a rd_chan strobe arrives in the same cycle.
- R11: asleep rises on the clock after a completion strobe (accepted or not) while sleep_mode is 1. It falls when sleep_mode is 0 or start_cmd is pulsed. A completion in the same cycle takes priority. A sleep setting made while idle leaves asleep at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | One-cycle end-of-conversion strobe from the sequencer |
| conv_ch | input | CH_W | Channel of the finished conversion |
| conv_data | input | RES_W | Result of the finished conversion |
| en_set | input | NUM_CH | Channel enable write mask, one cycle |
| en_clr | input | NUM_CH | Channel disable write mask, one cycle |
| rd_chan | input | 1 | Read strobe for a per-channel data register |
| rd_chan_sel | input | CH_W | Channel addressed by the data-register read |
| rd_last | input | 1 | Read strobe for the last-converted data register |
| rd_status | input | 1 | Read strobe for the status register |
| sleep_mode | input | 1 | Sleep setting from the mode register |
| start_cmd | input | 1 | Start command pulse |
| chan_en | output | NUM_CH | Channel enable register |
| chan_rdata | output | RES_W | Stored result of channel rd_chan_sel |
| last_data | output | RES_W | Last accepted result |
| last_ch | output | CH_W | Source channel of last_data |
| eoc_flags | output | NUM_CH | Per-channel end-of-conversion flags |
| ovr_flags | output | NUM_CH | Per-channel overrun flags |
| drdy | output | 1 | Global data-ready flag |
| govr | output | 1 | Global overrun flag |
| asleep | output | 1 | Converter sleep state |

## Verification
The bench sets up each collision on purpose. One case reads channel z while channel y completes and x holds a set flag: a design that decodes the wrong index clears x and leaves z set. Another disables one channel while another channel overruns: a design that lets the disable mask the completion loses both govr and the channel's overrun. A third reads status in the same cycle as a completion on a channel whose flag has just been cleared: a design that gives set priority there leaves a stale overrun. The remaining cases cover a completion on a channel disabled before or during its conversion, which a faulty gate would let raise its flag even under a concurrent read, and a sleep setting made while idle, which a level-sensitive design would apply at once.

// File: rtl/adcrs_pkg.sv
package adcrs_pkg;

  // Next value of a sticky flag: a set in the same cycle outranks a clear.
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // A completion counts only for a channel enabled before this cycle
  // and not being disabled in this cycle.
  function automatic logic accept_done(logic done, logic en_now, logic dis_now);
    return done & en_now & ~dis_now;
  endfunction

  // Sleep state: entered only at a conversion end, left on a start or mode drop.
  function automatic logic sleep_next(logic cur, logic mode, logic done, logic start);
    return (done & mode) | (cur & mode & ~start);
  endfunction

endpackage

// File: rtl/adcrs_enable.sv
module adcrs_enable #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] en_set,
  input  logic [NUM_CH-1:0] en_clr,
  output logic [NUM_CH-1:0] chan_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_en <= '0;
    else        chan_en <= (chan_en | en_set) & ~en_clr;
  end

endmodule

// File: rtl/adcrs_chan_slice.sv
module adcrs_chan_slice #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,       // accepted completion on this channel
  input  logic             rd_clr,    // a read consumes this channel's data
  input  logic             stat_clr,  // status register read
  input  logic [RES_W-1:0] din,
  output logic [RES_W-1:0] dout,
  output logic             eoc,
  output logic             ovr,
  output logic             ovr_raise
);
  import adcrs_pkg::*;

  // Overrun only when unread data is overwritten (not consumed this cycle).
  assign ovr_raise = hit & eoc & ~rd_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      eoc  <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      eoc <= flag_next(eoc, hit, rd_clr);
      ovr <= flag_next(ovr, ovr_raise, stat_clr);
      if (hit) dout <= din;
    end
  end

endmodule

// File: rtl/adcrs_global.sv
module adcrs_global #(
  parameter int RES_W = 10,
  parameter int CH_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [CH_W-1:0]  ch,
  input  logic [RES_W-1:0] din,
  input  logic             rd_last,
  input  logic             rd_status,
  output logic             drdy,
  output logic             govr,
  output logic [RES_W-1:0] last_data,
  output logic [CH_W-1:0]  last_ch,
  output logic             govr_raise
);
  import adcrs_pkg::*;

  // Independent of which channel produced the pending data.
  assign govr_raise = acc & drdy & ~rd_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drdy      <= 1'b0;
      govr      <= 1'b0;
      last_data <= '0;
      last_ch   <= '0;
    end else begin
      drdy <= flag_next(drdy, acc, rd_last);
      govr <= flag_next(govr, govr_raise, rd_status);
      if (acc) begin
        last_data <= din;
        last_ch   <= ch;
      end
    end
  end

endmodule

// File: rtl/adcrs_sleep.sv
module adcrs_sleep (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_done,
  input  logic sleep_mode,
  input  logic start_cmd,
  output logic asleep
);
  import adcrs_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) asleep <= 1'b0;
    else        asleep <= sleep_next(asleep, sleep_mode, conv_done, start_cmd);
  end

endmodule

// File: rtl/adcrs_top.sv
module adcrs_top #(
  parameter  int NUM_CH = 8,
  parameter  int RES_W  = 10,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [CH_W-1:0]   conv_ch,
  input  logic [RES_W-1:0]  conv_data,
  input  logic [NUM_CH-1:0] en_set,
  input  logic [NUM_CH-1:0] en_clr,
  input  logic              rd_chan,
  input  logic [CH_W-1:0]   rd_chan_sel,
  input  logic              rd_last,
  input  logic              rd_status,
  input  logic              sleep_mode,
  input  logic              start_cmd,
  output logic [NUM_CH-1:0] chan_en,
  output logic [RES_W-1:0]  chan_rdata,
  output logic [RES_W-1:0]  last_data,
  output logic [CH_W-1:0]   last_ch,
  output logic [NUM_CH-1:0] eoc_flags,
  output logic [NUM_CH-1:0] ovr_flags,
  output logic              drdy,
  output logic              govr,
  output logic              asleep
);
  import adcrs_pkg::*;

  // Named internal events, observed by the bound checker.
  logic              acc_done;
  logic [NUM_CH-1:0] acc_vec;
  logic [NUM_CH-1:0] eoc_clr_vec;
  logic [NUM_CH-1:0] ovr_raise_vec;
  logic              govr_raise;
  logic [RES_W-1:0]  data_arr [NUM_CH];

  adcrs_enable #(.NUM_CH(NUM_CH)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_set  (en_set),
    .en_clr  (en_clr),
    .chan_en (chan_en)
  );

  assign acc_done = accept_done(conv_done, chan_en[conv_ch], en_clr[conv_ch]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign acc_vec[i]     = acc_done && (conv_ch == CH_W'(i));
    assign eoc_clr_vec[i] = (rd_chan && (rd_chan_sel == CH_W'(i))) ||
                            (rd_last && (last_ch == CH_W'(i)));

    adcrs_chan_slice #(.RES_W(RES_W)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (acc_vec[i]),
      .rd_clr    (eoc_clr_vec[i]),
      .stat_clr  (rd_status),
      .din       (conv_data),
      .dout      (data_arr[i]),
      .eoc       (eoc_flags[i]),
      .ovr       (ovr_flags[i]),
      .ovr_raise (ovr_raise_vec[i])
    );
  end

  assign chan_rdata = data_arr[rd_chan_sel];

  adcrs_global #(.RES_W(RES_W), .CH_W(CH_W)) u_global (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc_done),
    .ch         (conv_ch),
    .din        (conv_data),
    .rd_last    (rd_last),
    .rd_status  (rd_status),
    .drdy       (drdy),
    .govr       (govr),
    .last_data  (last_data),
    .last_ch    (last_ch),
    .govr_raise (govr_raise)
  );

  adcrs_sleep u_sleep (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_done  (conv_done),
    .sleep_mode (sleep_mode),
    .start_cmd  (start_cmd),
    .asleep     (asleep)
  );

endmodule

// File: rtl/adcrs_checker.sv
module adcrs_checker #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_done,
  input logic [CH_W-1:0]   conv_ch,
  input logic [NUM_CH-1:0] en_clr,
  input logic              rd_chan,
  input logic [CH_W-1:0]   rd_chan_sel,
  input logic              rd_last,
  input logic              rd_status,
  input logic              sleep_mode,
  input logic [NUM_CH-1:0] chan_en,
  input logic [RES_W-1:0]  last_data,
  input logic [CH_W-1:0]   last_ch,
  input logic [NUM_CH-1:0] eoc_flags,
  input logic [NUM_CH-1:0] ovr_flags,
  input logic              drdy,
  input logic              govr,
  input logic              asleep,
  input logic              acc_done,
  input logic [NUM_CH-1:0] acc_vec,
  input logic [NUM_CH-1:0] ovr_raise_vec,
  input logic              govr_raise
);

  // R3
  acc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_vec));

  // R3
  eoc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((eoc_flags & ~$past(eoc_flags) & ~$past(acc_vec)) == '0));

  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_chan && !acc_done && !rd_last) |=>
      (eoc_flags == ($past(eoc_flags) & ~(NUM_CH'(1) << $past(rd_chan_sel)))));

  // R5
  drdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> drdy);

  // R6
  ovr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovr_raise_vec) |=> ((ovr_flags & $past(ovr_raise_vec)) == $past(ovr_raise_vec)));

  // R7
  govr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && drdy && !rd_last) |=> govr);

  // R7
  govr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    govr_raise |=> govr);

  // R8
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !acc_done) |=> (ovr_flags == '0 && !govr));

  // R9
  disable_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && drdy && !rd_last && (|en_clr)) |=> govr);

  // R10
  rejected_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && (!chan_en[conv_ch] || en_clr[conv_ch])) |=>
      ($stable(last_data) && $stable(last_ch)));

  // R11
  sleep_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(conv_done && sleep_mode));

endmodule

bind adcrs_top adcrs_checker #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .conv_done     (conv_done),
  .conv_ch       (conv_ch),
  .en_clr        (en_clr),
  .rd_chan       (rd_chan),
  .rd_chan_sel   (rd_chan_sel),
  .rd_last       (rd_last),
  .rd_status     (rd_status),
  .sleep_mode    (sleep_mode),
  .chan_en       (chan_en),
  .last_data     (last_data),
  .last_ch       (last_ch),
  .eoc_flags     (eoc_flags),
  .ovr_flags     (ovr_flags),
  .drdy          (drdy),
  .govr          (govr),
  .asleep        (asleep),
  .acc_done      (acc_done),
  .acc_vec       (acc_vec),
  .ovr_raise_vec (ovr_raise_vec),
  .govr_raise    (govr_raise)
);

// File: tb/test_adcrs_top.sv
`timescale 1ns/1ps
module test_adcrs_top;
  localparam int N = 8;
  localparam int W = 10;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_done = 0, rd_chan = 0, rd_last = 0, rd_status = 0;
  logic sleep_mode = 0, start_cmd = 0;
  logic [CW-1:0] conv_ch = '0, rd_chan_sel = '0;
  logic [W-1:0]  conv_data = '0;
  logic [N-1:0]  en_set = '0, en_clr = '0;
  logic [N-1:0]  chan_en, eoc_flags, ovr_flags;
  logic [W-1:0]  chan_rdata, last_data;
  logic [CW-1:0] last_ch;
  logic          drdy, govr, asleep;

  always #5 clk = ~clk;

  adcrs_top #(.NUM_CH(N), .RES_W(W)) i_adcrs_top (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_ch(conv_ch),
    .conv_data(conv_data), .en_set(en_set), .en_clr(en_clr), .rd_chan(rd_chan),
    .rd_chan_sel(rd_chan_sel), .rd_last(rd_last), .rd_status(rd_status),
    .sleep_mode(sleep_mode), .start_cmd(start_cmd), .chan_en(chan_en),
    .chan_rdata(chan_rdata), .last_data(last_data), .last_ch(last_ch),
    .eoc_flags(eoc_flags), .ovr_flags(ovr_flags), .drdy(drdy), .govr(govr),
    .asleep(asleep)
  );

  int n_cmp = 0;
  int n_mis = 0;
  bit finished = 0;

  // ---------------- behavioural reference model ----------------
  bit [N-1:0] m_en, m_eoc, m_ovr;
  bit         m_drdy, m_govr, m_sleep;
  int         m_data [N];
  int         m_last, m_lastch;

  task automatic model_reset();
    m_en = 0; m_eoc = 0; m_ovr = 0; m_drdy = 0; m_govr = 0; m_sleep = 0;
    m_last = 0; m_lastch = 0;
    foreach (m_data[k]) m_data[k] = 0;
  endtask

  task automatic model_step();
    bit taken, consumed;
    bit [N-1:0] e, o;
    bit d, g, s;
    int ch;
    ch = int'(conv_ch);
    taken = conv_done && m_en[ch] && !en_clr[ch];
    e = m_eoc; o = m_ovr; d = m_drdy; g = m_govr; s = m_sleep;
    if (rd_status) begin o = 0; g = 0; end
    for (int c = 0; c < N; c++) begin
      consumed = (rd_chan && int'(rd_chan_sel) == c) || (rd_last && m_lastch == c);
      if (consumed) e[c] = 0;
      if (taken && ch == c) begin
        if (m_eoc[c] && !consumed) o[c] = 1;
        e[c] = 1;
        m_data[c] = int'(conv_data);
      end
    end
    if (taken && m_drdy && !rd_last) g = 1;
    if (rd_last) d = 0;
    if (taken) begin d = 1; m_last = int'(conv_data); m_lastch = ch; end
    if (!sleep_mode || start_cmd) s = 0;
    if (conv_done && sleep_mode) s = 1;
    m_en = (m_en | en_set) & ~en_clr;
    m_eoc = e; m_ovr = o; m_drdy = d; m_govr = g; m_sleep = s;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2", "chan_en", chan_en, m_en);
    chk("R3", "eoc_flags", eoc_flags, m_eoc);
    chk("R6", "ovr_flags", ovr_flags, m_ovr);
    chk("R5", "drdy", drdy, m_drdy);
    chk("R7", "govr", govr, m_govr);
    chk("R3", "last_data", last_data, m_last);
    chk("R3", "last_ch", last_ch, m_lastch);
    chk("R11", "asleep", asleep, m_sleep);
    chk("R4", "chan_rdata", chan_rdata, m_data[rd_chan_sel]);
  endtask

  // One clock: inputs already set; compare at the following negedge; drop strobes.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    conv_done = 0; rd_chan = 0; rd_last = 0; rd_status = 0;
    start_cmd = 0; en_set = '0; en_clr = '0;
  endtask

  task automatic done_on(input int ch, input int val);
    conv_done = 1; conv_ch = CW'(ch); conv_data = W'(val);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_mis++;
      $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset eoc", eoc_flags, 0);
    chk("R1", "reset ovr", ovr_flags, 0);
    chk("R1", "reset en", chan_en, 0);
    chk("R1", "reset flags", {drdy, govr, asleep}, 0);
    chk("R1", "reset last", {last_data, last_ch}, 0);

    // R2 clear beats set on the same bit
    en_set = 8'hFF; en_clr = 8'h08; step();
    chk("R2", "set+clr same bit", chan_en, 8'hF7);
    en_set = 8'h08; step();
    chk("R2", "re-enable", chan_en, 8'hFF);

    // R3 accepted completion
    done_on(2, 10'h155); step();
    chk("R3", "eoc after done", eoc_flags, 8'h04);
    chk("R3", "last after done", {last_ch, last_data}, {3'd2, 10'h155});
    rd_chan_sel = 3'd2; #1;
    chk("R4", "chan_rdata ch2", chan_rdata, 10'h155);

    // R9 disable ch6 while ch2 overruns
    done_on(2, 10'h0AA); en_clr = 8'h40; step();
    chk("R9", "govr on disable collision", govr, 1);
    chk("R9", "ovr ch2 on disable collision", ovr_flags, 8'h04);

    // R8 status read clears overruns
    rd_status = 1; step();
    chk("R8", "ovr cleared", {ovr_flags, govr}, 0);
    chk("R8", "eoc kept", eoc_flags, 8'h04);
    done_on(2, 10'h011); step();
    chk("R6", "ovr re-set", ovr_flags, 8'h04);
    rd_chan = 1; rd_chan_sel = 3'd2; step();
    rd_status = 1; done_on(2, 10'h022); step();
    chk("R8", "ovr clear despite same-cycle done", ovr_flags, 0);
    chk("R8", "eoc set by same-cycle done", eoc_flags, 8'h04);

    // R4 read of z while y completes, x pending
    rd_last = 1; step();
    rd_status = 1; step();
    done_on(3, 10'h033); step();
    done_on(0, 10'h100); step();
    done_on(1, 10'h201); rd_chan = 1; rd_chan_sel = 3'd3; step();
    chk("R4", "read z clears z only", eoc_flags, 8'h03);

    // R7 unread data from a channel outside the collision
    rd_last = 1; step();
    rd_status = 1; step();
    done_on(5, 10'h055); step();
    chk("R7", "govr clear before", govr, 0);
    done_on(7, 10'h077); step();
    chk("R7", "govr from third channel", govr, 1);

    // R10 disabled channel completion
    en_clr = 8'h10; step();
    done_on(4, 10'h3FF); rd_chan = 1; rd_chan_sel = 3'd0; step();
    chk("R10", "no eoc on disabled ch4", eoc_flags[4], 0);
    chk("R10", "last unchanged", last_ch, 7);
    done_on(3, 10'h3EE); en_clr = 8'h08; step();
    chk("R10", "no eoc on same-cycle disable", eoc_flags[3], 0);
    chk("R10", "last data unchanged", last_data, 10'h077);

    // R5 read-last vs completion
    rd_last = 1; done_on(0, 10'h0F0); step();
    chk("R5", "drdy set wins", drdy, 1);
    rd_last = 1; step();
    chk("R5", "drdy cleared", drdy, 0);

    // R11 sleep needs a conversion end
    sleep_mode = 1;
    repeat (5) step();
    chk("R11", "idle sleep not taken", asleep, 0);
    start_cmd = 1; step();
    done_on(0, 10'h001); step();
    chk("R11", "sleep after conversion", asleep, 1);
    sleep_mode = 0; step();
    chk("R11", "wake on mode clear", asleep, 0);

    // random traffic, compared every clock
    en_set = 8'hFF; step();
    for (int i = 0; i < 6000; i++) begin
      conv_done   = ($urandom_range(0, 2) != 0);
      conv_ch     = CW'($urandom_range(0, N-1));
      conv_data   = W'($urandom);
      rd_chan     = ($urandom_range(0, 2) == 0);
      rd_chan_sel = CW'($urandom_range(0, N-1));
      rd_last     = ($urandom_range(0, 3) == 0);
      rd_status   = ($urandom_range(0, 4) == 0);
      en_set      = ($urandom_range(0, 5) == 0) ? N'($urandom) : '0;
      en_clr      = ($urandom_range(0, 9) == 0) ? N'($urandom) : '0;
      start_cmd   = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 19) == 0) sleep_mode = ~sleep_mode;
      step();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule